// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple memory-mapped bus with 16-bit data. A prescaler divides the reference clock into ticks, nominally 10 ms each, and a 15-bit counter counts those ticks down. Every action that changes the timer's state only takes effect when the write carries the matching 16-bit key: reloading the counter, stopping it, starting it again, and clearing the record of a past timeout. Stopping takes two keyed writes in a row. If any other bus access falls between them, the sequence is abandoned.

When the counter runs out, the block drives a system reset pulse of fixed length. It then reloads the counter from the programmed timeout and keeps running. One tick before expiry, a warning event is latched. That event drives an interrupt line through a mask bit. Software can acknowledge the event or force it. A sticky status word records that a timeout reset happened. The live count can be read, together with a flag that marks a cycle in which the count is about to change. A debug-mode input freezes the countdown unless software has set an override bit.

The bus has no back-pressure. Every access with `bus_sel` high completes in its own cycle. Read data is valid in that same cycle, and a write takes effect at the clock edge that ends it. The block carries no data streams, so there is no valid/ready interface.

Top module: `kwdt_top`

## Requirements
- R1: The timeout register at offset 0x04 holds 15 bits. Bit 15 of a write is dropped and reads back as 0.
- R2: Writing 0xFEED to offset 0x00 loads the counter from the timeout register at that edge, whether the timer is running or stopped. Any other value has no effect. A feed takes priority over an expiry tick in the same cycle, so no reset follows.
- R3: While the timer is running and not frozen, the counter drops by one on every tick. A tick occurs once every `TICK_DIV` clock cycles.
- R4: Writing 0x2BAD to offset 0x08, followed at the very next bus access by 0xCAFE to offset 0x0C, stops the counter. Offset 0x0C reads 0xDABE while stopped and 0x0000 while running. Any other access between the two writes aborts the sequence.
- R5: Writing 0xACED to offset 0x1C restarts a stopped timer, and counting resumes from the held count. Any other value has no effect.
- R6: A tick that finds the count at 1 or 0 raises `sys_rst_o` for exactly `RST_CYCLES` cycles. The counter reloads from the timeout register and keeps running, so a count of N expires on the N-th tick.
- R7: Offset 0x10 reads 0xCFE8 once an expiry has happened and 0x0000 before. Writing 0xE8B4 returns it to 0x0000. Other values have no effect.
- R8: The tick that takes the count from 2 to 1 sets bit 0 of the event register at offset 0x20. This happens exactly `TICK_DIV` cycles before `sys_rst_o` rises.
- R9: Writing 1 to bit 0 of offset 0x20 clears the event. Writing 1 to bit 0 of offset 0x28 sets it, and 0x28 reads 0. `irq_o` is high exactly when the event bit and mask bit 0 at offset 0x24 are both set.
- R10: Offset 0x14 returns the live count in bits 14:0. Bit 15 is 1 in exactly those cycles where the count will change at the next edge.
- R11: At offset 0x18, bit 1 reads `dbg_mode_i` and bit 0 is a read/write override. With `dbg_mode_i` high and the override clear, the counter is frozen. With the override set, it keeps counting.
- R12: Offsets with no register read 0, and writes to them have no effect.
- R13: After reset the timer runs with count and timeout equal to `DEF_TIMEOUT`. Status, event, mask and override are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the prescaler and all registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 must be 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the read cycle |
| dbg_mode_i | input | 1 | Debug mode active |
| irq_o | output | 1 | Masked warning interrupt |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
Two functions can land on the same edge: a keyed feed write and the tick that would expire the counter. The bench keeps its own count of clock edges since reset, so it knows which edges carry a tick. It reads the count every cycle until the count is 1 and the next edge is a tick, then places the feed write on exactly that edge. The result passes if no reset pulse appears in the following two tick periods and the count reads back as the timeout value. A second overlap is the warning and the reset. The bench judges it by checking that the interrupt rises exactly one tick period before the reset, and that the reset comes on the N-th tick after the start.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DW = 16;
  localparam int CW = DW - 1;

  localparam logic [3:0] IDX_FEED  = 4'd0;
  localparam logic [3:0] IDX_TMO   = 4'd1;
  localparam logic [3:0] IDX_STOP1 = 4'd2;
  localparam logic [3:0] IDX_STOP2 = 4'd3;
  localparam logic [3:0] IDX_STAT  = 4'd4;
  localparam logic [3:0] IDX_CNT   = 4'd5;
  localparam logic [3:0] IDX_DBG   = 4'd6;
  localparam logic [3:0] IDX_GO    = 4'd7;
  localparam logic [3:0] IDX_EVT   = 4'd8;
  localparam logic [3:0] IDX_MSK   = 4'd9;
  localparam logic [3:0] IDX_FRC   = 4'd10;

  localparam logic [DW-1:0] KEY_FEED    = 16'hFEED;
  localparam logic [DW-1:0] KEY_STOP1   = 16'h2BAD;
  localparam logic [DW-1:0] KEY_STOP2   = 16'hCAFE;
  localparam logic [DW-1:0] KEY_GO      = 16'hACED;
  localparam logic [DW-1:0] KEY_CLR     = 16'hE8B4;
  localparam logic [DW-1:0] VAL_STOPPED = 16'hDABE;
  localparam logic [DW-1:0] VAL_TIMEDOUT = 16'hCFE8;

  typedef struct packed {
    logic feed;
    logic stop;
    logic go;
    logic clr;
    logic ack;
    logic force_ev;
  } cmd_t;
endpackage

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
  parameter int DIV = 328
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  if (DIV > 1) begin : g_gap
    // R3: ticks are spaced, never back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs import kwdt_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          warn_i,
  input  logic          expire_i,
  input  logic          en_i,
  input  logic          pend_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dbg_i,
  output logic          feed_o,
  output logic          stop_o,
  output logic          go_o,
  output logic [CW-1:0] timeout_o,
  output logic          keep_o,
  output logic          irq_o
);
  logic          hit;
  logic [3:0]    idx;
  logic [15:0]   wsel;
  cmd_t          cmd;
  logic          arm_q, to_q, evt_q, msk_q, keep_q;
  logic [CW-1:0] tmo_q;

  assign idx  = bus_addr[5:2];
  assign hit  = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 6) == '0);
  assign wsel = (hit && bus_wr) ? (16'(1) << idx) : '0;

  always_comb begin
    cmd.feed     = wsel[IDX_FEED]  && (bus_wdata == KEY_FEED);
    cmd.stop     = wsel[IDX_STOP2] && (bus_wdata == KEY_STOP2) && arm_q;
    cmd.go       = wsel[IDX_GO]    && (bus_wdata == KEY_GO);
    cmd.clr      = wsel[IDX_STAT]  && (bus_wdata == KEY_CLR);
    cmd.ack      = wsel[IDX_EVT]   && bus_wdata[0];
    cmd.force_ev = wsel[IDX_FRC]   && bus_wdata[0];
  end

  assign feed_o    = cmd.feed;
  assign stop_o    = cmd.stop;
  assign go_o      = cmd.go;
  assign timeout_o = tmo_q;
  assign keep_o    = keep_q;
  assign irq_o     = evt_q & msk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= CW'(DEF_TIMEOUT);
      arm_q  <= 1'b0;
      to_q   <= 1'b0;
      evt_q  <= 1'b0;
      msk_q  <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      if (wsel[IDX_TMO]) tmo_q <= bus_wdata[CW-1:0];
      if (bus_sel) arm_q <= wsel[IDX_STOP1] && (bus_wdata == KEY_STOP1);
      if (expire_i) to_q <= 1'b1;
      else if (cmd.clr) to_q <= 1'b0;
      if (warn_i || cmd.force_ev) evt_q <= 1'b1;
      else if (cmd.ack) evt_q <= 1'b0;
      if (wsel[IDX_MSK]) msk_q <= bus_wdata[0];
      if (wsel[IDX_DBG]) keep_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_wr) begin
      case (idx)
        IDX_TMO:   bus_rdata = {1'b0, tmo_q};
        IDX_STOP2: bus_rdata = en_i ? '0 : VAL_STOPPED;
        IDX_STAT:  bus_rdata = to_q ? VAL_TIMEDOUT : '0;
        IDX_CNT:   bus_rdata = {pend_i, cnt_i};
        IDX_DBG:   bus_rdata = {14'd0, dbg_i, keep_q};
        IDX_EVT:   bus_rdata = {15'd0, evt_q};
        IDX_MSK:   bus_rdata = {15'd0, msk_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R7: the timeout record is only ever set by an expiry
  a_r7_status_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(expire_i));
  // R8: the event only appears after a warning tick or a forced write
  a_r8_event_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(warn_i || cmd.force_ev));
  // R9: an acknowledge with no competing source clears the event
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.ack && !warn_i && !cmd.force_ev) |=> !evt_q);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter import kwdt_pkg::*; #(
  parameter int DEF_TIMEOUT = 6000,
  parameter int RST_CYCLES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          dbg_i,
  input  logic          keep_i,
  input  logic          feed_i,
  input  logic          stop_i,
  input  logic          go_i,
  input  logic [CW-1:0] timeout_i,
  output logic [CW-1:0] cnt_o,
  output logic          en_o,
  output logic          warn_o,
  output logic          expire_o,
  output logic          pend_o,
  output logic          sys_rst_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          en_q;
  logic [RW-1:0] rst_q;
  logic          run, step, low;

  assign run      = en_q && (!dbg_i || keep_i);
  assign step     = tick_i && run;
  assign low      = (cnt_q <= CW'(1));
  assign expire_o = step && !feed_i && low;
  assign warn_o   = step && !feed_i && (cnt_q == CW'(2));
  assign pend_o   = feed_i || step;
  assign cnt_o    = cnt_q;
  assign en_o     = en_q;
  assign sys_rst_o = (rst_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(DEF_TIMEOUT);
      en_q  <= 1'b1;
      rst_q <= '0;
    end else begin
      if (feed_i) cnt_q <= timeout_i;
      else if (step) cnt_q <= low ? timeout_i : cnt_q - 1'b1;
      if (stop_i) en_q <= 1'b0;
      else if (go_i) en_q <= 1'b1;
      if (expire_o) rst_q <= RW'(RST_CYCLES);
      else if (rst_q != '0) rst_q <= rst_q - 1'b1;
    end
  end

  // R4: a stopped counter only moves on a feed
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !feed_i) |=> $stable(cnt_q));
  // R11: debug mode without override freezes the count
  a_r11_dbg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && !keep_i && !feed_i) |=> $stable(cnt_q));
  // R6: the reset pulse starts with the counter reloaded
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> (cnt_q == $past(timeout_i)));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top import kwdt_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int TICK_DIV    = 328,
  parameter int DEF_TIMEOUT = 6000,
  parameter int RST_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              dbg_mode_i,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic          tick, feed, stop, go, keep, en, warn, expire, pend;
  logic [CW-1:0] timeout, cnt;

  kwdt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  kwdt_regs #(.ADDR_W(ADDR_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .warn_i(warn), .expire_i(expire), .en_i(en), .pend_i(pend),
    .cnt_i(cnt), .dbg_i(dbg_mode_i),
    .feed_o(feed), .stop_o(stop), .go_o(go),
    .timeout_o(timeout), .keep_o(keep), .irq_o(irq_o)
  );

  kwdt_counter #(.DEF_TIMEOUT(DEF_TIMEOUT), .RST_CYCLES(RST_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_i(dbg_mode_i),
    .keep_i(keep), .feed_i(feed), .stop_i(stop), .go_i(go),
    .timeout_i(timeout), .cnt_o(cnt), .en_o(en), .warn_o(warn),
    .expire_o(expire), .pend_o(pend), .sys_rst_o(sys_rst_o)
  );
endmodule

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;
  localparam int D = 4, DEF = 12, RC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, sel = 1'b0, wr = 1'b0, dbg = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0, rdata, v;
  logic irq, srst;
  int ecnt = 0, cyc = 0, n_run = 0, n_fail = 0;

  kwdt_top #(.ADDR_W(6), .TICK_DIV(D), .DEF_TIMEOUT(DEF), .RST_CYCLES(RC)) u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .dbg_mode_i(dbg),
    .irq_o(irq), .sys_rst_o(srst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) ecnt <= ecnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_bus(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_bus(input logic [5:0] a, output logic [15:0] d, output int e);
    @(negedge clk); sel = 1; wr = 0; addr = a; #0.5; d = rdata; e = ecnt;
    @(negedge clk); sel = 0;
  endtask

  task automatic stop_timer();
    wr_bus(6'h08, 16'h2BAD); wr_bus(6'h0C, 16'hCAFE);
  endtask

  initial begin
    wait (cyc >= 60000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<60000 cycles", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int e1, e2, es, er, ir, w;
    logic [15:0] v1;
    logic seen;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    rd_bus(6'h14, v, e1); check("R13 count", v[14:0], DEF);
    rd_bus(6'h04, v, e1); check("R13 timeout", v, DEF);
    rd_bus(6'h10, v, e1); check("R13 status", v, 0);
    rd_bus(6'h0C, v, e1); check("R13 running", v, 0);
    rd_bus(6'h20, v, e1); check("R13 event", v, 0);
    check("R13 outputs", {irq, srst}, 0);
    // R4 stop sequence
    stop_timer();
    rd_bus(6'h0C, v, e1); check("R4 stopped", v, 16'hDABE);
    rd_bus(6'h14, v1, e1); repeat (3*D) @(negedge clk);
    rd_bus(6'h14, v, e1); check("R4 count held", v, v1);
    // R1 timeout width
    wr_bus(6'h04, 16'h8005); rd_bus(6'h04, v, e1); check("R1 bit15 dropped", v, 5);
    wr_bus(6'h04, 16'd7);
    // R2 feed keying
    wr_bus(6'h00, 16'h1234); rd_bus(6'h14, v, e1); check("R2 wrong key", v[14:0], v1[14:0]);
    wr_bus(6'h00, 16'hFEED); rd_bus(6'h14, v, e1); check("R2 feed loads", v[14:0], 7);
    // R12 unmapped offsets
    wr_bus(6'h2C, 16'hFFFF); rd_bus(6'h2C, v, e1); check("R12 read zero", v, 0);
    rd_bus(6'h3C, v, e1); check("R12 read zero hi", v, 0);
    rd_bus(6'h04, v, e1); check("R12 no side effect", v, 7);
    // R5 restart
    wr_bus(6'h04, 16'd30); wr_bus(6'h00, 16'hFEED);
    wr_bus(6'h1C, 16'h1111); rd_bus(6'h0C, v, e1); check("R5 wrong key", v, 16'hDABE);
    wr_bus(6'h1C, 16'hACED); es = ecnt;
    rd_bus(6'h14, v, e1); check("R5 resumes held", v[14:0], 30 - (e1/D - es/D));
    // R3 countdown arithmetic
    rd_bus(6'h14, v1, e1); repeat (2*D+1) @(negedge clk);
    rd_bus(6'h14, v, e2); check("R3 decrement", v[14:0], v1[14:0] - (e2/D - e1/D));
    // R4 aborted sequence
    wr_bus(6'h08, 16'h2BAD); rd_bus(6'h10, v, e1); wr_bus(6'h0C, 16'hCAFE);
    rd_bus(6'h0C, v, e1); check("R4 abort", v, 0);
    // R10 update flag
    wr_bus(6'h00, 16'hFEED);
    for (int i = 0; i < 2*D; i++) begin
      @(negedge clk); sel = 1; wr = 0; addr = 6'h14; #0.5;
      check("R10 flag running", rdata[15], ((ecnt + 1) % D == 0) ? 1 : 0);
    end
    @(negedge clk); sel = 0;
    stop_timer();
    for (int i = 0; i < D; i++) begin
      @(negedge clk); sel = 1; wr = 0; addr = 6'h14; #0.5;
      check("R10 flag stopped", rdata[15], 0);
    end
    @(negedge clk); sel = 0;
    // R6 R8 expiry and warning
    wr_bus(6'h20, 16'd1); wr_bus(6'h04, 16'd5); wr_bus(6'h24, 16'd1);
    wr_bus(6'h00, 16'hFEED); wr_bus(6'h1C, 16'hACED); es = ecnt;
    ir = -1; er = -1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq && ir < 0) ir = ecnt;
      if (srst) begin er = ecnt; break; end
    end
    sel = 1; wr = 0; addr = 6'h14; #0.5;
    check("R6 reload", rdata[14:0], 5);
    check("R6 fifth tick", er/D - es/D, 5);
    check("R8 one tick early", er - ir, D);
    w = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); sel = 0;
      if (!srst) break;
      w++;
    end
    check("R6 pulse width", w, RC);
    rd_bus(6'h0C, v, e1); check("R6 still running", v, 0);
    stop_timer();
    // R7 status
    rd_bus(6'h10, v, e1); check("R7 timed out", v, 16'hCFE8);
    wr_bus(6'h10, 16'h1234); rd_bus(6'h10, v, e1); check("R7 wrong key", v, 16'hCFE8);
    wr_bus(6'h10, 16'hE8B4); rd_bus(6'h10, v, e1); check("R7 cleared", v, 0);
    // R9 event controls
    check("R9 irq from warning", irq, 1);
    wr_bus(6'h20, 16'd1); rd_bus(6'h20, v, e1); check("R9 ack", v, 0);
    check("R9 irq after ack", irq, 0);
    wr_bus(6'h24, 16'd0); wr_bus(6'h28, 16'd1);
    rd_bus(6'h20, v, e1); check("R9 force", v, 1);
    check("R9 masked", irq, 0);
    rd_bus(6'h28, v, e1); check("R9 force reads 0", v, 0);
    wr_bus(6'h24, 16'd1); check("R9 unmasked", irq, 1);
    wr_bus(6'h20, 16'd1); check("R9 ack irq", irq, 0);
    // R11 debug freeze and override
    dbg = 1;
    rd_bus(6'h18, v, e1); check("R11 debug bit", v, 2);
    wr_bus(6'h04, 16'd30); wr_bus(6'h00, 16'hFEED); wr_bus(6'h1C, 16'hACED);
    rd_bus(6'h14, v1, e1); repeat (3*D) @(negedge clk);
    rd_bus(6'h14, v, e2); check("R11 frozen", v[14:0], 30);
    wr_bus(6'h18, 16'd1); rd_bus(6'h18, v, e1); check("R11 override bit", v, 3);
    rd_bus(6'h14, v1, e1); repeat (2*D) @(negedge clk);
    rd_bus(6'h14, v, e2); check("R11 override counts", v[14:0], v1[14:0] - (e2/D - e1/D));
    wr_bus(6'h18, 16'd0); dbg = 0;
    stop_timer();
    // R2 feed on the expiry tick
    wr_bus(6'h04, 16'd3); wr_bus(6'h00, 16'hFEED); wr_bus(6'h1C, 16'hACED);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); sel = 1; wr = 0; addr = 6'h14; #0.5;
      if (rdata[14:0] == 1 && (ecnt + 1) % D == 0) begin
        wr = 1; addr = 6'h00; wdata = 16'hFEED; seen = 1; break;
      end
    end
    check("R2 collision reached", seen, 1);
    @(negedge clk); wr = 0; addr = 6'h14; #0.5;
    check("R2 feed wins count", rdata[14:0], 3);
    seen = 0;
    for (int k = 0; k < 2*D; k++) begin
      @(negedge clk); sel = 0;
      if (srst) seen = 1;
    end
    check("R2 feed wins no reset", seen, 0);
    stop_timer();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule